// File: doc/BRIEF.md
# EEPROM Page Write Buffer with Upper-Half Write Protect

This block sits behind a two-wire serial slave engine and in front of a small byte-addressable storage array of 256 or 512 bytes, modelled as registers. In a write session it takes the word address from the first received byte and then gathers data bytes into a 16-byte page buffer. When the engine reports a STOP after whole bytes, it commits the gathered bytes to the array in one timed internal write cycle and raises `busy_o` while that cycle runs. In a read session it presents bytes from an auto-incrementing address counter.

The engine tells the block that a session has begun by pulsing `sess_start_i` once the slave address has matched. At the same time it gives the transfer direction and, in the 512-byte variant, the top address bit taken from the slave address byte. Received bytes arrive on a valid/ready stream. `wr_ready_o` is high only while a write session is open. A byte moves on any cycle where valid and ready are both high, and the engine holds its byte until then. Outgoing bytes leave on a second valid/ready stream. `rd_valid_o` is high for the whole of a read session. `rd_data_o` holds steady until `rd_ready_i` takes the byte, and the counter then moves on. The write-protect input `wp_i` stops commits into the upper half of the array.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset `busy_o`, `wr_ready_o` and `rd_valid_o` are low, the address counter is 0 and every array byte reads 8'hFF.
- R2: In a write session the first accepted byte sets address bits [7:0]. With ADDR_W=9, address bit 8 is the value of `sess_a8_i` captured at `sess_start_i`.
- R3: Each later accepted byte goes to buffer lane address[3:0], and the low 4 address bits then increment modulo 16 inside the page. A 17th or later byte therefore overwrites an earlier lane.
- R4: A commit starts only on `stop_i` with `stop_partial_i` low, in a write session with at least one data byte. A partial STOP, a new `sess_start_i`, or a STOP after only the address byte discards the buffer and leaves the array unchanged. Received bytes still advance the counter.
- R5: A commit holds `busy_o` high for exactly T_WR cycles, starting the cycle after STOP. Only the lanes loaded in that session change, and they are visible once `busy_o` is low.
- R6: While `busy_o` is high, `sess_start_i` is ignored: `wr_ready_o` and `rd_valid_o` stay low.
- R7: `wp_i` is sampled in the last busy cycle. When it is high and the page lies in the upper half (address MSB = 1), no byte of the page is written. Pages in the lower half are written whatever `wp_i` is.
- R8: In a read session `rd_data_o` is the array byte at the counter. Each handshake increments the counter, wrapping from the last location to 0. While `rd_ready_i` is low, `rd_valid_o` and `rd_data_o` hold.
- R9: After a commit the counter holds the page base plus (start offset + byte count) mod 16, so a current-address read continues there. After an address-only write session it holds the loaded address.
- R10: `stop_i` closes any session. In a read session `wr_ready_o` stays low, so write bytes offered there are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sess_start_i | input | 1 | Pulse: slave address matched, session opens |
| sess_rd_i | input | 1 | Direction with `sess_start_i`: 1 read, 0 write |
| sess_a8_i | input | 1 | Address bit 8 from the slave address byte (ADDR_W=9) |
| stop_i | input | 1 | Pulse: STOP seen on the bus |
| stop_partial_i | input | 1 | With `stop_i`: STOP arrived inside a byte |
| wp_i | input | 1 | Write protect for the upper half of the array |
| wr_valid_i | input | 1 | Received byte valid |
| wr_data_i | input | 8 | Received byte |
| wr_ready_o | output | 1 | Block accepts a received byte |
| rd_valid_o | output | 1 | Outgoing byte valid |
| rd_data_o | output | 8 | Outgoing byte |
| rd_ready_i | input | 1 | Engine takes the outgoing byte |
| busy_o | output | 1 | Internal write cycle running |

## Verification
The assertions check, on every cycle, that no stream handshake can occur during a write cycle. They also check that every busy run lasts exactly T_WR cycles, that a loaded byte always marks its lane, that no lane write reaches a protected upper-half page, and that an outgoing byte holds while stalled. The bench scenarios show the rest. These are the in-page wrap and overwrite, the discard rules for partial STOP, restart and address-only sessions, and where the counter sits after a commit. A full-array read-back that wraps to 0 compares every byte against a model built from the page sweep.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int PAGE_BYTES = 16;
  localparam int LANE_W     = $clog2(PAGE_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WADDR = 2'd1,
    ST_WDATA = 2'd2,
    ST_READ  = 2'd3
  } pwb_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf
  import pwb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      ld_i,
  input  logic [LANE_W-1:0]         lane_i,
  input  logic [7:0]                data_i,
  output logic [PAGE_BYTES*8-1:0]   bytes_o,
  output logic [PAGE_BYTES-1:0]     mask_o
);
  logic [7:0] lane_q [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
    end else if (clr_i) begin
      mask_o <= '0;
    end else if (ld_i) begin
      mask_o[lane_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_i) lane_q[lane_i] <= data_i;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign bytes_o[g*8 +: 8] = lane_q[g];
  end

  // R3: a loaded byte always marks its lane as present
  a_r3_lane_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !clr_i) |=> mask_o[$past(lane_i)]);
endmodule

// File: rtl/pwb_wr_timer.sv
module pwb_wr_timer #(
  parameter int T_WR = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(T_WR + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (fire_i)      cnt_q <= CNT_W'(T_WR);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  // checker counter for the busy window length
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R5: every busy window is exactly T_WR cycles long
  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_o) |-> (run_q == (CNT_W+1)'(T_WR - 1)));
  // R6: no new commit while one is running
  a_r6_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> !busy_o);
endmodule

// File: rtl/pwb_array.sv
module pwb_array
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic                        prot_i,
  input  logic [ADDR_W-LANE_W-1:0]    page_i,
  input  logic [PAGE_BYTES-1:0]       lane_en_i,
  input  logic [PAGE_BYTES*8-1:0]     lane_data_i,
  input  logic [ADDR_W-1:0]           raddr_i,
  output logic [7:0]                  rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      for (int l = 0; l < PAGE_BYTES; l++) begin
        if (lane_en_i[l]) mem_q[{page_i, LANE_W'(l)}] <= lane_data_i[l*8 +: 8];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R7: no lane write reaches a protected upper-half page
  a_r7_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && prot_i) |-> (lane_en_i == '0));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int T_WR   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sess_start_i,
  input  logic       sess_rd_i,
  input  logic       sess_a8_i,
  input  logic       stop_i,
  input  logic       stop_partial_i,
  input  logic       wp_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  output logic       wr_ready_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  input  logic       rd_ready_i,
  output logic       busy_o
);
  localparam int PAGE_W = ADDR_W - LANE_W;

  pwb_state_e              state_q;
  logic [ADDR_W-1:0]       addr_q;
  logic                    a8_q;
  logic                    wr_hs, rd_hs, fire, done, buf_clr, buf_ld, prot;
  logic [PAGE_BYTES-1:0]   mask;
  logic [PAGE_BYTES*8-1:0] bytes;
  logic [ADDR_W-1:0]       load_addr;

  assign wr_ready_o = (state_q == ST_WADDR) || (state_q == ST_WDATA);
  assign rd_valid_o = (state_q == ST_READ);
  assign wr_hs      = wr_valid_i && wr_ready_o;
  assign rd_hs      = rd_valid_o && rd_ready_i;
  assign buf_clr    = sess_start_i && !busy_o;
  assign buf_ld     = wr_hs && (state_q == ST_WDATA) && !buf_clr && !stop_i;
  assign fire       = stop_i && !stop_partial_i && !buf_clr
                      && (state_q == ST_WDATA) && (mask != '0);
  assign prot       = wp_i && addr_q[ADDR_W-1];

  if (ADDR_W > 8) begin : g_hi_bit
    assign load_addr = {a8_q, wr_data_i};
  end else begin : g_no_hi_bit
    assign load_addr = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      a8_q    <= 1'b0;
    end else if (buf_clr) begin
      state_q <= sess_rd_i ? ST_READ : ST_WADDR;
      a8_q    <= sess_a8_i;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else begin
      if (wr_hs && state_q == ST_WADDR) begin
        addr_q  <= load_addr;
        state_q <= ST_WDATA;
      end else if (buf_ld) begin
        addr_q[LANE_W-1:0] <= addr_q[LANE_W-1:0] + 1'b1;
      end else if (rd_hs) begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  pwb_page_buf u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (buf_clr),
    .ld_i    (buf_ld),
    .lane_i  (addr_q[LANE_W-1:0]),
    .data_i  (wr_data_i),
    .bytes_o (bytes),
    .mask_o  (mask)
  );

  pwb_wr_timer #(.T_WR(T_WR)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .busy_o (busy_o),
    .done_o (done)
  );

  pwb_array #(.ADDR_W(ADDR_W)) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (done),
    .prot_i      (prot),
    .page_i      (addr_q[ADDR_W-1 -: PAGE_W]),
    .lane_en_i   (prot ? '0 : mask),
    .lane_data_i (bytes),
    .raddr_i     (addr_q),
    .rdata_o     (rd_data_o)
  );

  // R6: no stream handshake can happen during a write cycle
  a_r6_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !(wr_ready_o || rd_valid_o));
  // R8: a stalled outgoing byte holds
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i && !stop_i && !sess_start_i)
      |=> (rd_valid_o && $stable(rd_data_o)));
  // R10: streams never open together
  a_r10_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready_o && rd_valid_o));
endmodule

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;
  localparam int AW = 9;
  localparam int TW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic sess_start_i = 0, sess_rd_i = 0, sess_a8_i = 0;
  logic stop_i = 0, stop_partial_i = 0, wp_i = 0;
  logic wr_valid_i = 0, rd_ready_i = 0;
  logic [7:0] wr_data_i = 0;
  logic wr_ready_o, rd_valid_o, busy_o;
  logic [7:0] rd_data_o;

  int checks = 0, fails = 0;
  logic [7:0] model [DEPTH];
  int exp_addr = 0;

  always #4 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .T_WR(TW)) u_eeprom_page_writer (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic open_sess(input bit rd, input bit a8);
    @(negedge clk); sess_start_i = 1; sess_rd_i = rd; sess_a8_i = a8;
    @(negedge clk); sess_start_i = 0;
  endtask

  task automatic put(input logic [7:0] b);
    wr_valid_i = 1; wr_data_i = b;
    @(negedge clk); wr_valid_i = 0;
  endtask

  task automatic close_sess(input bit partial);
    stop_i = 1; stop_partial_i = partial;
    @(negedge clk); stop_i = 0; stop_partial_i = 0;
  endtask

  task automatic busy_run(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  task automatic seek(input int a);
    open_sess(0, a[8]); put(a[7:0]); close_sess(0);
    chk(busy_o == 0, "R4 address-only no commit", busy_o, 0);
    exp_addr = a;
  endtask

  task automatic get(input string req);
    chk(rd_valid_o && rd_data_o == model[exp_addr], req, rd_data_o, model[exp_addr]);
    rd_ready_i = 1;
    @(negedge clk); rd_ready_i = 0;
    exp_addr = (exp_addr + 1) % DEPTH;
  endtask

  function automatic logic [7:0] pat(input int p, input int k, input int s);
    return 8'((p * 37 + k * 11 + s) ^ 8'h5A);
  endfunction

  task automatic page_write(input int p, input int off, input int n, input int s, input bit wp);
    int run;
    open_sess(0, p[4]);
    put({p[3:0], off[3:0]});
    for (int k = 0; k < n; k++) put(pat(p, k, s));
    wp_i = wp;
    close_sess(0);
    busy_run(run);
    chk(run == TW, "R5 busy length", run, TW);
    wp_i = 0;
    if (!(wp && p >= DEPTH / 32))
      for (int k = 0; k < n; k++) model[p * 16 + (off + k) % 16] = pat(p, k, s);
    exp_addr = p * 16 + (off + n) % 16;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !wr_ready_o && !rd_valid_o, "R1 reset outputs", {busy_o, wr_ready_o, rd_valid_o}, 0);
    open_sess(1, 0);
    for (int k = 0; k < 4; k++) get("R1 erased contents");
    close_sess(0);

    // sweep every page, protect on odd pages; R2 (a8), R7
    for (int p = 0; p < DEPTH / 16; p++) page_write(p, 0, 16, 0, p[0]);

    // R6: start attempt during busy
    open_sess(0, 0); put(8'h40); put(8'h99); close_sess(0);
    model[64] = 8'h99; exp_addr = 65;
    open_sess(0, 0);
    chk(busy_o && !wr_ready_o && !rd_valid_o, "R6 start ignored while busy", wr_ready_o, 0);
    while (busy_o) @(negedge clk);

    // R3 wrap inside page, R9 current-address read
    page_write(3, 10, 9, 3, 0);
    open_sess(1, 0);
    chk(rd_data_o == model[51], "R9 counter after commit", rd_data_o, model[51]);
    close_sess(0);
    page_write(20, 0, 20, 7, 0);
    chk(model[320] == pat(20, 16, 7), "R3 model overwrite", model[320], pat(20, 16, 7));
    seek(320);
    open_sess(1, 0);
    for (int k = 0; k < 16; k++) get("R3 overwrite lanes");
    close_sess(0);

    // R4 discards
    open_sess(0, 0); put(8'h70); put(8'h11); put(8'h22); close_sess(1);
    chk(busy_o == 0, "R4 partial stop no commit", busy_o, 0);
    open_sess(0, 0); put(8'h70); put(8'h33);
    open_sess(1, 0);
    chk(busy_o == 0 && rd_valid_o, "R4 restart discards", busy_o, 0);
    close_sess(0);
    seek(112);
    open_sess(1, 0);
    for (int k = 0; k < 4; k++) get("R4 array unchanged");
    // R8 hold while not ready
    begin
      logic [7:0] held;
      held = rd_data_o;
      @(negedge clk); @(negedge clk);
      chk(rd_valid_o && rd_data_o == held, "R8 hold when stalled", rd_data_o, held);
    end
    // R10 write offered in read session
    wr_valid_i = 1; wr_data_i = 8'hC3;
    @(negedge clk);
    chk(!wr_ready_o, "R10 no write in read", wr_ready_o, 0);
    wr_valid_i = 0;
    get("R10 read continues");
    close_sess(0);
    chk(!rd_valid_o && !wr_ready_o, "R10 stop closes", rd_valid_o, 0);

    // full read-back with wrap; R7 and R8
    seek(0);
    open_sess(1, 0);
    for (int k = 0; k < DEPTH + 2; k++) get("R8 R7 full read and wrap");
    close_sess(0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule